// File: doc/BRIEF.md
# Peripheral Clock-Gating State Controller

This block owns the clock enable and the reset of a single peripheral module. Software picks one of three requested states with a small write port: the module can be switched off, switched on, or left in an auto-wake sleep. In the sleep state the module clock is gated and the module reset is released. The first read or write that reaches the module on its bus port wakes it up. That access is stalled until the clock is running. From then on the module stays on with no further software action.

Any change that turns the clock on passes through a waking phase of `WAKE_LAT` cycles. The status port shows this phase, and a busy bit stays high while a change is still in progress. A request written during the waking phase is held and applied once the clock is on. When the module is switched off, a bus access is not left hanging: it completes at once with an error flag.

Top module: `pclk_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, `mod_rst_n` and `mod_clk_en` are 0. On the first edge after release, `mod_rst_n` becomes 1, `stat_state` reads 2'b00 (off) and `stat_busy` reads 0.
- R2: A write (`cfg_wr`=1) is taken at the clock edge. The codes on `cfg_wdata` are 2'b00 off, 2'b01 on and 2'b11 auto-wake. A move from on to off or to auto-wake, or between off and auto-wake, shows on `stat_state` right after that edge, and `mod_clk_en` is 0 from then on.
- R3: Writing on (2'b01) while the clock is off moves `stat_state` to 2'b10 (waking) with `stat_busy`=1. `mod_clk_en` rises, and `stat_state` becomes 2'b01, exactly `WAKE_LAT` edges after the write edge.
- R4: In auto-wake (`stat_state`=2'b11), `mod_clk_en` is 0 and `mod_rst_n` is 1. A `bus_req` seen at an edge moves the block to waking with no write. `mod_clk_en` rises `WAKE_LAT` edges later.
- R5: In the on state, `bus_ready` is high only in a cycle where `mod_clk_en` was also high in the cycle before. A stalled access therefore gets `bus_ready` one cycle after the clock comes on. In steady on, `bus_ready` follows `bus_req` in the same cycle and `bus_err` is 0.
- R6: After a wake-up, `stat_state` stays 2'b01 for as long as no new write arrives.
- R7: In the off state, `bus_req` is answered in the same cycle with `bus_ready`=1 and `bus_err`=1. The state does not change. `bus_err` is never 1 in any other state.
- R8: A write of the reserved code 2'b10 changes nothing.
- R9: A write made while waking is held and applied on the edge after `mod_clk_en` rises. If several writes arrive, the last one wins. `stat_busy` stays 1 until the held write is applied.
- R10: If `bus_req` and a write arrive in the same cycle in auto-wake, the wake-up goes ahead and the write is held as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for a requested state |
| cfg_wdata | input | 2 | Requested state code |
| stat_state | output | 2 | Current state: 00 off, 01 on, 10 waking, 11 auto-wake |
| stat_busy | output | 1 | A wake-up or a held request is still in progress |
| mod_clk_en | output | 1 | Module clock enable |
| mod_rst_n | output | 1 | Module reset, active low |
| bus_req | input | 1 | Module bus access pending, held until completion |
| bus_ready | output | 1 | Access completes this cycle |
| bus_err | output | 1 | Completed access was refused (module off) |

## Verification
In auto-wake, a bus access and a software write can land in the same cycle. The block must let the wake-up win and hold the write back. The bench provokes this with a vector row that raises `bus_req` and writes code 2'b00 together while the block is asleep. It then checks that the block passes through waking, turns the clock on for one cycle with busy still set, and only after that applies the off state. At that point the stalled access completes with an error. The same hold-back path is also reached by writes that arrive during a software-started wake-up. Those writes show that the last one wins.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'b00,
    ST_ON   = 2'b01,
    ST_WAKE = 2'b10,
    ST_AUTO = 2'b11
  } pcg_state_e;

  localparam logic [1:0] CODE_OFF  = 2'b00;
  localparam logic [1:0] CODE_ON   = 2'b01;
  localparam logic [1:0] CODE_RSVD = 2'b10;
  localparam logic [1:0] CODE_AUTO = 2'b11;

  function automatic logic code_ok(input logic [1:0] code);
    return code != CODE_RSVD;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned lat);
    return (lat > 1) ? $clog2(lat) : 1;
  endfunction
endpackage

// File: rtl/pcg_req_filter.sv
module pcg_req_filter
  import pcg_pkg::*;
(
  input  logic       wr,
  input  logic [1:0] wdata,
  output logic       wr_ok,
  output logic [1:0] wr_code
);
  assign wr_ok   = wr && code_ok(wdata);
  assign wr_code = wdata;
endmodule

// File: rtl/pcg_wake_timer.sv
module pcg_wake_timer
  import pcg_pkg::*;
#(
  parameter int unsigned WAKE_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = cnt_width(WAKE_LAT);
  localparam logic [CW-1:0] LAST = CW'(WAKE_LAT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (start)  cnt_q <= '0;
    else if (run)    cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/pcg_bus_resp.sv
module pcg_bus_resp
  import pcg_pkg::*;
(
  input  pcg_state_e state,
  input  logic       clk_on_d,
  input  logic       req,
  output logic       ready,
  output logic       err
);
  always_comb begin
    ready = 1'b0;
    err   = 1'b0;
    if (req) begin
      if (state == ST_OFF) begin
        ready = 1'b1;
        err   = 1'b1;
      end else if (state == ST_ON && clk_on_d) begin
        ready = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pclk_gate_ctrl.sv
module pclk_gate_ctrl
  import pcg_pkg::*;
#(
  parameter int unsigned WAKE_LAT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_wdata,
  output logic [1:0] stat_state,
  output logic       stat_busy,
  output logic       mod_clk_en,
  output logic       mod_rst_n,
  input  logic       bus_req,
  output logic       bus_ready,
  output logic       bus_err
);
  pcg_state_e state_q, state_d;
  logic       pend_vld_q, pend_vld_d;
  logic [1:0] pend_code_q, pend_code_d;
  logic       clk_on_d_q;
  logic       wr_ok;
  logic [1:0] wr_code;
  logic       wake_start, wake_done;
  logic       apply_vld, apply_now, wake_by_bus;
  logic [1:0] apply_code;

  pcg_req_filter u_filt (
    .wr(cfg_wr), .wdata(cfg_wdata), .wr_ok(wr_ok), .wr_code(wr_code)
  );

  pcg_wake_timer #(.WAKE_LAT(WAKE_LAT)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(wake_start),
    .run(state_q == ST_WAKE), .done(wake_done)
  );

  pcg_bus_resp u_resp (
    .state(state_q), .clk_on_d(clk_on_d_q), .req(bus_req),
    .ready(bus_ready), .err(bus_err)
  );

  // A fresh write beats a held one; held ones exist only right after waking.
  assign apply_vld   = wr_ok || pend_vld_q;
  assign apply_code  = wr_ok ? wr_code : pend_code_q;
  assign wake_by_bus = (state_q == ST_AUTO) && bus_req;
  assign apply_now   = (state_q != ST_WAKE) && !wake_by_bus && apply_vld;

  always_comb begin
    state_d     = state_q;
    wake_start  = 1'b0;
    pend_vld_d  = 1'b0;
    pend_code_d = pend_code_q;
    if (state_q == ST_WAKE || wake_by_bus) begin
      pend_vld_d = pend_vld_q;
      if (wr_ok) begin
        pend_vld_d  = 1'b1;
        pend_code_d = wr_code;
      end
    end
    if (state_q == ST_WAKE) begin
      if (wake_done) state_d = ST_ON;
    end else if (wake_by_bus) begin
      state_d    = ST_WAKE;
      wake_start = 1'b1;
    end else if (apply_now) begin
      case (apply_code)
        CODE_ON: begin
          if (state_q != ST_ON) begin
            state_d    = ST_WAKE;
            wake_start = 1'b1;
          end
        end
        CODE_AUTO: state_d = ST_AUTO;
        default:   state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_OFF;
      pend_vld_q  <= 1'b0;
      pend_code_q <= CODE_OFF;
      clk_on_d_q  <= 1'b0;
      mod_rst_n   <= 1'b0;
    end else begin
      state_q     <= state_d;
      pend_vld_q  <= pend_vld_d;
      pend_code_q <= pend_code_d;
      clk_on_d_q  <= mod_clk_en;
      mod_rst_n   <= 1'b1;
    end
  end

  assign mod_clk_en = (state_q == ST_ON);
  assign stat_state = state_q;
  assign stat_busy  = (state_q == ST_WAKE) || pend_vld_q;
endmodule

// File: rtl/pclk_gate_ctrl_chk.sv
module pclk_gate_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] stat_state,
  input logic       stat_busy,
  input logic       mod_clk_en,
  input logic       mod_rst_n,
  input logic       bus_req,
  input logic       bus_ready,
  input logic       bus_err,
  input logic       apply_now
);
  AST_AUTO_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    stat_state == 2'b11 |-> !mod_clk_en && mod_rst_n); // R4
  AST_AUTO_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    stat_state == 2'b11 && bus_req |=> stat_state == 2'b10); // R4
  AST_WAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stat_state == 2'b10 |-> stat_busy && !mod_clk_en); // R3
  AST_ON_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_state == 2'b01 && !apply_now |=> stat_state == 2'b01); // R6
  AST_READY_AFTER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready && !bus_err |-> mod_clk_en && $past(mod_clk_en)); // R5
  AST_OFF_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    stat_state == 2'b00 && bus_req |-> bus_ready && bus_err); // R7
  AST_ERR_ONLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> stat_state == 2'b00); // R7
endmodule

bind pclk_gate_ctrl pclk_gate_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stat_state(stat_state), .stat_busy(stat_busy),
  .mod_clk_en(mod_clk_en), .mod_rst_n(mod_rst_n), .bus_req(bus_req),
  .bus_ready(bus_ready), .bus_err(bus_err), .apply_now(apply_now)
);

// File: tb/sim_pclk_gate_ctrl.sv
module sim_pclk_gate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;
  localparam int NROW = 32;
  localparam int WDOG = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_wdata = 2'b00;
  logic       bus_req = 1'b0;
  logic [1:0] stat_state;
  logic       stat_busy, mod_clk_en, mod_rst_n, bus_ready, bus_err;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pclk_gate_ctrl #(.WAKE_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .stat_state(stat_state), .stat_busy(stat_busy), .mod_clk_en(mod_clk_en),
    .mod_rst_n(mod_rst_n), .bus_req(bus_req), .bus_ready(bus_ready),
    .bus_err(bus_err)
  );

  // {wr, wdata[1:0], req | state[1:0], clk_en, ready, err, busy}, LAT = 4
  localparam logic [9:0] VEC [NROW] = '{
    10'b0_00_0_00_0_0_0_0, // 0  R1 off after reset
    10'b0_00_1_00_0_1_1_0, // 1  R7 access refused at once
    10'b1_11_0_00_0_0_0_0, // 2  R2 write auto
    10'b0_00_0_11_0_0_0_0, // 3  R2 asleep
    10'b0_00_1_11_0_0_0_0, // 4  R4 access seen
    10'b0_00_1_10_0_0_0_1, // 5  R4 waking
    10'b0_00_1_10_0_0_0_1, // 6
    10'b0_00_1_10_0_0_0_1, // 7
    10'b0_00_1_10_0_0_0_1, // 8
    10'b0_00_1_01_1_0_0_0, // 9  R5 clock on, still stalled
    10'b0_00_1_01_1_1_0_0, // 10 R5 ready
    10'b0_00_0_01_1_0_0_0, // 11 R6
    10'b0_00_0_01_1_0_0_0, // 12 R6
    10'b1_10_0_01_1_0_0_0, // 13 R8 reserved write
    10'b0_00_0_01_1_0_0_0, // 14 R8 unchanged
    10'b1_00_1_01_1_1_0_0, // 15 R5 steady ready, write off
    10'b0_00_0_00_0_0_0_0, // 16 R2 off next cycle
    10'b1_01_0_00_0_0_0_0, // 17 R3 write on
    10'b0_00_0_10_0_0_0_1, // 18 R3
    10'b1_00_0_10_0_0_0_1, // 19 R9 held write off
    10'b1_11_0_10_0_0_0_1, // 20 R9 held write auto (last wins)
    10'b0_00_0_10_0_0_0_1, // 21 R3
    10'b0_00_0_01_1_0_0_1, // 22 R9 on, held write pending
    10'b0_00_0_11_0_0_0_0, // 23 R9 auto applied
    10'b1_00_1_11_0_0_0_0, // 24 R10 access and write together
    10'b0_00_1_10_0_0_0_1, // 25 R10
    10'b0_00_1_10_0_0_0_1, // 26
    10'b0_00_1_10_0_0_0_1, // 27
    10'b0_00_1_10_0_0_0_1, // 28
    10'b0_00_1_01_1_0_0_1, // 29 R10 on for one cycle
    10'b0_00_1_00_0_1_1_0, // 30 R10 off applied, access refused
    10'b0_00_0_00_0_0_0_0  // 31 R7 idle
  };

  function automatic string row_req(input int i);
    case (i)
      0: return "R1";
      1, 31: return "R7";
      2, 3, 16: return "R2";
      4, 5, 6, 7, 8: return "R4";
      9, 10, 15: return "R5";
      11, 12: return "R6";
      13, 14: return "R8";
      17, 18, 21: return "R3";
      19, 20, 22, 23: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got cycle %0d expected end", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset outs", {6'd0, mod_rst_n, mod_clk_en}, 8'd0);
    rst_n = 1'b1;
    @(posedge clk);

    for (int i = 0; i < NROW; i++) begin
      @(negedge clk);
      cfg_wr    = VEC[i][9];
      cfg_wdata = VEC[i][8:7];
      bus_req   = VEC[i][6];
      #1;
      check(row_req(i), $sformatf("row %0d", i),
            {1'b0, mod_rst_n, stat_state, mod_clk_en, bus_ready, bus_err, stat_busy},
            {2'b01, VEC[i][5:0]});
    end
    @(negedge clk);
    cfg_wr = 1'b0;
    bus_req = 1'b0;

    // R3: reset in the middle of a wake-up returns to off with module reset low
    cfg_wr = 1'b1; cfg_wdata = 2'b01;
    @(negedge clk);
    cfg_wr = 1'b0;
    #1;
    check("R3", "waking", {6'd0, stat_state}, 8'd2);
    rst_n = 1'b0;
    #1;
    check("R1", "reset mid wake", {4'd0, stat_state, mod_clk_en, mod_rst_n}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "after release",
          {4'd0, stat_state, stat_busy, mod_rst_n}, 8'b0000_0001);

    // R4: auto-wake with LAT clock-off cycles, counted per cycle
    cfg_wr = 1'b1; cfg_wdata = 2'b11;
    @(negedge clk);
    cfg_wr = 1'b0; bus_req = 1'b1;
    @(negedge clk);
    for (int k = 0; k < LAT; k++) begin
      check("R4", $sformatf("clk off wake cycle %0d", k), {7'd0, mod_clk_en}, 8'd0);
      @(negedge clk);
    end
    check("R4", "clk on after LAT", {7'd0, mod_clk_en}, 8'd1);
    bus_req = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule